// File: doc/BRIEF.md
# Phase Lock Start Sequencer

This block turns a one-shot frequency trigger and the polarity and down-slope indications of a beat signal into a fixed, repeatable start-up order for a phase lock interval. After the trigger it waits for the next negative-to-positive zero crossing of the beat and raises a hold output. It then waits for a down-slope pulse and drives the active-low counter-load output low. This releases two divide-by-32 counters. Each counter has its own programmable first-edge delay. A programmable number of clocks later it raises the run output, which starts the reference trajectory. Run stays high for the rest of the interval.

The RF inputs are clock-enable strobes that are synchronous to the logic clock. An abort input returns the sequencer to idle from any state. Abort clears hold and run, drives load high again and clears both divided outputs.

Top module: `lock_start_seq`

## Requirements
- R1: After reset, hold, run, div_a and div_b are 0 and load_n is 1.
- R2: hold rises one cycle after the first sampled rising edge of `pol` that occurs strictly after the cycle in which `freq_trig` was sampled high. A rising edge of `pol` before the trigger, or in the same cycle as the trigger, is ignored. hold then stays high until abort.
- R3: A `dn_pulse` is acted on only while hold is high and the counters are not yet released. It drives load_n low in the following cycle. A `dn_pulse` seen before hold has no effect.
- R4: run rises exactly `run_dly`+1 cycles after load_n falls, where `run_dly` is a 16-bit unsigned count. run then stays high until abort.
- R5: div_a first rises `dly_cfg[4:0]`+1 cycles after load_n falls. div_b first rises `dly_cfg[12:8]`+1 cycles after load_n falls. The other bits of `dly_cfg` have no effect.
- R6: After its first rising edge, each divided output toggles on every 16th strobe of its own RF input. Each half period is therefore 16 strobes, and the output runs at 1/32 of the strobe rate. Strobes seen before the first edge do not count.
- R7: An abort sampled high returns the block to its reset output state on the next cycle. Abort wins over a down-slope pulse or a run assertion that falls in the same cycle.
- R8: div_a and div_b are 0 whenever load_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Synchronous reset, active low |
| abort | input | 1 | Return to idle |
| freq_trig | input | 1 | Frequency threshold trigger pulse |
| pol | input | 1 | Beat signal polarity, 1 = positive |
| dn_pulse | input | 1 | Down-slope pulse of the beat signal |
| rf_a_stb | input | 1 | Strobe for RF input A |
| rf_b_stb | input | 1 | Strobe for RF input B |
| dly_cfg | input | 16 | First-edge delays: A in [4:0], B in [12:8] |
| run_dly | input | 16 | Clocks from counter release to run, minus one |
| hold | output | 1 | Hold for phase lock |
| load_n | output | 1 | Counter load, low = counters running |
| run | output | 1 | Reference trajectory running |
| div_a | output | 1 | RF A divided by 32 |
| div_b | output | 1 | RF B divided by 32 |

## Verification
Two pairs of events can land in the same cycle. The first pair is the trigger and a polarity rise. The bench drives both in one cycle and requires hold to stay low until a later rise arrives. The second pair is abort and the run assertion. The bench drives abort exactly on the edge where run would rise, and requires run to stay low and the block to be back in its idle output state one cycle later.

// File: rtl/lss_pkg.sv
// Shared types and sizes for the phase lock start sequencer.
// Assumes a single logic clock; all inputs synchronous to it.
package lss_pkg;
    localparam int DLY_W   = 5;   // first-edge delay width
    localparam int RUN_W   = 16;  // run delay width
    localparam int CFG_W   = 16;  // packed delay config width
    localparam int FIELD_STRIDE = 8; // bit spacing of delay fields
    localparam int DIV_RATIO = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_HOLD,
        ST_DELAY,
        ST_RUN
    } seq_state_t;
endpackage

// File: rtl/lss_fsm.sv
// Sequencing state machine: trigger -> polarity rise -> down-slope ->
// delay -> run. Abort has top priority and returns to idle.
// Assumes pulse inputs are one-cycle, synchronous to clk.
module lss_fsm
    import lss_pkg::*;
#(
    parameter int RUN_W_P = RUN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               freq_trig,
    input  logic               pol,
    input  logic               dn_pulse,
    input  logic [RUN_W_P-1:0] run_dly,
    output logic               hold,
    output logic               load_n,
    output logic               run
);
    seq_state_t         state_q;
    logic [RUN_W_P-1:0] cnt_q;
    logic               pol_q;
    logic               pol_rise;

    // Detect a negative-to-positive zero crossing.
    assign pol_rise = pol & ~pol_q;

    // Polarity history; reset high so a high level after reset is no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) pol_q <= 1'b1;
        else        pol_q <= pol;
    end

    // State progression and release-to-run delay count.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE:  if (freq_trig) state_q <= ST_ARMED;
                ST_ARMED: if (pol_rise)  state_q <= ST_HOLD;
                ST_HOLD: if (dn_pulse) begin
                    state_q <= ST_DELAY;
                    cnt_q   <= '0;
                end
                ST_DELAY: begin
                    if (cnt_q == run_dly) state_q <= ST_RUN;
                    else                  cnt_q   <= cnt_q + 1'b1;
                end
                ST_RUN:   state_q <= ST_RUN;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the state register.
    always_comb begin
        hold   = (state_q == ST_HOLD) || (state_q == ST_DELAY) || (state_q == ST_RUN);
        load_n = !((state_q == ST_DELAY) || (state_q == ST_RUN));
        run    = (state_q == ST_RUN);
    end
endmodule

// File: rtl/lss_div32.sv
// Strobe divider with programmable first-edge delay. While clear is high
// the output is 0. Once released it waits dly clocks, drives the output
// high, then toggles it on every RATIO/2-th strobe.
module lss_div32 #(
    parameter int DLY_W = 5,
    parameter int RATIO = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             stb,
    input  logic [DLY_W-1:0] dly,
    output logic             div_o
);
    localparam int HALF  = RATIO / 2;
    localparam int SUB_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF - 1);

    logic [DLY_W-1:0] wait_q;
    logic             started_q;
    logic [SUB_W-1:0] sub_q;
    logic             out_q;

    // First-edge delay, then strobe counting with output toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wait_q    <= '0;
            started_q <= 1'b0;
            sub_q     <= '0;
            out_q     <= 1'b0;
        end else if (!started_q) begin
            if (wait_q == dly) begin
                started_q <= 1'b1;
                out_q     <= 1'b1;
                sub_q     <= '0;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end else if (stb) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                out_q <= ~out_q;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign div_o = out_q;
endmodule

// File: rtl/lock_start_seq.sv
// Top of the phase lock start sequencer: one state machine and two
// delayed divide-by-32 counters. Abort clears the counters in the same
// edge as the state machine.
module lock_start_seq
    import lss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             freq_trig,
    input  logic             pol,
    input  logic             dn_pulse,
    input  logic             rf_a_stb,
    input  logic             rf_b_stb,
    input  logic [CFG_W-1:0] dly_cfg,
    input  logic [RUN_W-1:0] run_dly,
    output logic             hold,
    output logic             load_n,
    output logic             run,
    output logic             div_a,
    output logic             div_b
);
    localparam int NCH = 2;

    logic [NCH-1:0] stb_v;
    logic [NCH-1:0] div_v;
    logic           div_clear;

    lss_fsm #(.RUN_W_P(RUN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .freq_trig (freq_trig),
        .pol       (pol),
        .dn_pulse  (dn_pulse),
        .run_dly   (run_dly),
        .hold      (hold),
        .load_n    (load_n),
        .run       (run)
    );

    // Counters idle while load is high or an abort is arriving.
    assign div_clear = load_n | abort;
    assign stb_v     = {rf_b_stb, rf_a_stb};

    // One delayed divider per RF channel; delay fields every FIELD_STRIDE bits.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        lss_div32 #(.DLY_W(DLY_W), .RATIO(DIV_RATIO)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (div_clear),
            .stb   (stb_v[ch]),
            .dly   (dly_cfg[ch*FIELD_STRIDE +: DLY_W]),
            .div_o (div_v[ch])
        );
    end

    assign div_a = div_v[0];
    assign div_b = div_v[1];
endmodule

// File: rtl/lss_checker.sv
// Temporal checks on the start sequencer ports, bound to every instance.
module lss_checker (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic pol,
    input logic rf_a_stb,
    input logic rf_b_stb,
    input logic hold,
    input logic load_n,
    input logic run,
    input logic div_a,
    input logic div_b
);
    AST_HOLD_AFTER_POL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(pol));                              // R2
    AST_LOAD_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> hold);                                        // R3
    AST_RUN_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !load_n);                                         // R4
    AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !abort) |=> run);                                 // R4
    AST_A_TOGGLE_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(div_a) && !load_n) |-> $past(rf_a_stb));           // R6
    AST_B_TOGGLE_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(div_b) && !load_n) |-> $past(rf_b_stb));           // R6
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!hold && !run && load_n && !div_a && !div_b)); // R7
    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |-> (!div_a && !div_b));                           // R8
endmodule

bind lock_start_seq lss_checker u_lss_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (abort),
    .pol      (pol),
    .rf_a_stb (rf_a_stb),
    .rf_b_stb (rf_b_stb),
    .hold     (hold),
    .load_n   (load_n),
    .run      (run),
    .div_a    (div_a),
    .div_b    (div_b)
);

// File: tb/test_lock_start_seq.sv
`timescale 1ns/1ps
// Bench: a vector table of delay settings walked by one loop, then
// directed tests for reset, same-cycle events and ignored inputs.
module test_lock_start_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort = 1'b0;
    logic        freq_trig = 1'b0;
    logic        pol = 1'b0;
    logic        dn_pulse = 1'b0;
    logic        rf_a_stb = 1'b0;
    logic        rf_b_stb = 1'b0;
    logic [15:0] dly_cfg = '0;
    logic [15:0] run_dly = '0;
    logic        hold, load_n, run, div_a, div_b;

    int n_chk = 0;
    int n_fail = 0;
    int stb_per = 1;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lock_start_seq i_lock_start_seq (
        .clk(clk), .rst_n(rst_n), .abort(abort), .freq_trig(freq_trig),
        .pol(pol), .dn_pulse(dn_pulse), .rf_a_stb(rf_a_stb),
        .rf_b_stb(rf_b_stb), .dly_cfg(dly_cfg), .run_dly(run_dly),
        .hold(hold), .load_n(load_n), .run(run), .div_a(div_a), .div_b(div_b)
    );

    // Strobe generator: one strobe every stb_per clocks.
    always @(negedge clk) begin
        stb_cnt  = (stb_cnt + 1) % stb_per;
        rf_a_stb = (stb_cnt == 0);
        rf_b_stb = (stb_cnt == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(hold == 0, {req, " hold"}, hold, 0);
        chk(run == 0, {req, " run"}, run, 0);
        chk(load_n == 1, {req, " load_n"}, load_n, 1);
        chk(div_a == 0 && div_b == 0, {req, " div"}, {div_b, div_a}, 0);
    endtask

    task automatic do_abort();
        @(negedge clk) abort = 1'b1;
        @(negedge clk) abort = 1'b0;
    endtask

    // Trigger, polarity rise, hold check, down-slope pulse; ends on the
    // sample where load_n should first be low.
    task automatic start_seq(input int a, input int b, input int r);
        dly_cfg = {3'b111, 5'(b), 3'b111, 5'(a)};
        run_dly = 16'(r);
        @(negedge clk) freq_trig = 1'b1;
        @(negedge clk) freq_trig = 1'b0;
        @(negedge clk) pol = 1'b1;
        @(negedge clk);
        chk(hold == 1, "R2 hold after crossing", hold, 1);
        pol = 1'b0;
        @(negedge clk) dn_pulse = 1'b1;
        @(negedge clk) dn_pulse = 1'b0;
        chk(load_n == 0, "R3 load_n after down pulse", load_n, 0);
    endtask

    // Vector fields: a_dly, b_dly, run_dly, strobe period.
    localparam int NVEC = 5;
    localparam int VEC [NVEC][4] = '{
        '{0,  0,   0, 1},
        '{5,  12, 40, 1},
        '{31, 0,   7, 2},
        '{3,  31, 100, 3},
        '{17, 9,   1, 1}
    };

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 reset");

        // Table walk: delays, run timing, divider half period (R4 R5 R6).
        for (int v = 0; v < NVEC; v++) begin
            int ra, fa, ra2, rb, rr;
            ra = -1; fa = -1; ra2 = -1; rb = -1; rr = -1;
            stb_per = VEC[v][3];
            start_seq(VEC[v][0], VEC[v][1], VEC[v][2]);
            for (int i = 1; i < 800; i++) begin
                @(negedge clk);
                if (div_a && ra < 0) ra = i;
                if (!div_a && ra >= 0 && fa < 0) fa = i;
                if (div_a && fa >= 0 && ra2 < 0) ra2 = i;
                if (div_b && rb < 0) rb = i;
                if (run && rr < 0) rr = i;
                if (ra2 >= 0 && rb >= 0 && rr >= 0) break;
            end
            chk(ra == VEC[v][0] + 1, "R5 div_a first edge", ra, VEC[v][0] + 1);
            chk(rb == VEC[v][1] + 1, "R5 div_b first edge", rb, VEC[v][1] + 1);
            chk(rr == VEC[v][2] + 1, "R4 run delay", rr, VEC[v][2] + 1);
            chk(ra2 - fa == 16 * VEC[v][3], "R6 low half period", ra2 - fa, 16 * VEC[v][3]);
            chk(run == 1, "R4 run stays", run, 1);
            do_abort();
            chk_idle("R7 abort from run");
        end
        stb_per = 1;

        // R2: a crossing with no trigger gives no hold.
        @(negedge clk) pol = 1'b1;
        @(negedge clk);
        chk(hold == 0, "R2 crossing without trigger", hold, 0);
        pol = 1'b0;

        // R2: a crossing in the trigger cycle is ignored; the next one counts.
        @(negedge clk) begin freq_trig = 1'b1; pol = 1'b1; end
        @(negedge clk) freq_trig = 1'b0;
        chk(hold == 0, "R2 same-cycle crossing ignored", hold, 0);
        pol = 1'b0;
        @(negedge clk) pol = 1'b1;
        @(negedge clk);
        chk(hold == 1, "R2 later crossing holds", hold, 1);
        pol = 1'b0;
        do_abort();
        chk_idle("R7 abort from hold");

        // R3: a down pulse before hold has no effect.
        @(negedge clk) freq_trig = 1'b1;
        @(negedge clk) begin freq_trig = 1'b0; dn_pulse = 1'b1; end
        @(negedge clk) dn_pulse = 1'b0;
        chk(load_n == 1, "R3 early down pulse ignored", load_n, 1);
        chk(hold == 0, "R3 early down pulse no hold", hold, 0);
        @(negedge clk) pol = 1'b1;
        @(negedge clk) pol = 1'b0;
        chk(hold == 1, "R2 hold after early pulse", hold, 1);
        chk(load_n == 1, "R8 load stays high in hold", load_n, 1);
        chk(div_a == 0 && div_b == 0, "R8 dividers idle in hold", {div_b, div_a}, 0);
        do_abort();

        // R7: abort on the very edge where run would rise (run_dly = 3).
        start_seq(2, 2, 3);
        for (int i = 1; i <= 3; i++) @(negedge clk);
        chk(run == 0, "R4 run not yet", run, 0);
        abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk_idle("R7 abort beats run");
        repeat (4) @(negedge clk);
        chk(run == 0, "R7 run stays low after abort", run, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule